// File: doc/BRIEF.md
# Accelerator Virtual-Memory Window Translator

This block sits between a hardware accelerator and a small paged local memory. The accelerator issues reads and writes using virtual addresses from the host application's own address space. The block looks the virtual page number up in a fully associative table of resident pages. Table slot `i` owns local frame `i`. On a hit, the access goes to local memory with the frame index placed above the unchanged page offset.

When the page is not resident, the block holds the accelerator stalled and raises an interrupt. It also records the faulting virtual address and whether the access was a read or a write. Host software copies the page into a free frame and writes the page number into that slot. It then writes the resume bit. The accelerator keeps its request asserted throughout, so the access that missed is accepted exactly once after the resume.

Software can also drop a slot when a page must be made coherent with an aliasing pointer elsewhere, and it can read a per-slot dirty mask to decide which pages need copying back.

Top module: `pagewin_xlate`

## Requirements
- R1: After reset, `mem_req`, `acc_stall` and `host_irq` are low, and the valid mask (register 2) and the dirty mask (register 3) read as zero.
- R2: An access whose virtual page matches a valid slot `s` gives `acc_ready` high in the same cycle. One cycle after acceptance, `mem_req` is high and `mem_paddr = {s, vaddr[OFF_W-1:0]}`, where `OFF_W = log2(PAGE_BYTES)`. In that same cycle `mem_we` and `mem_wdata` carry the accepted direction and data.
- R3: A request whose page matches no valid slot gives `acc_ready` low. From the next cycle, `acc_stall` and `host_irq` are high. No `mem_req` is issued while the stall is held.
- R4: On a miss, register 0 holds the faulting virtual address and register 1 reads `{bit1 = write, bit0 = pending}`. Both stay unchanged until software resumes, even if the accelerator changes its request.
- R5: Writing 1 to bit 0 of register 1 while a miss is pending clears `acc_stall` and `host_irq` in the next cycle. The still-held request is then retried and produces exactly one `mem_req` if the page is now resident, or a fresh miss if it is not.
- R6: An accepted write to slot `s` sets bit `s` of the dirty mask, and a read leaves the mask alone. Writing `s` to register 7 clears that dirty bit.
- R7: With register 4 holding slot `s`, writing a page number to register 5 marks slot `s` valid with its dirty bit clear. Reading register 5 returns that page number.
- R8: Writing `s` to register 6 clears both the valid bit and the dirty bit of slot `s`. A later access to the page that slot held then misses.
- R9: When two valid slots hold the same page number, the lower-numbered slot supplies the frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_req | input | 1 | Accelerator access request, held until accepted |
| acc_we | input | 1 | Access is a write |
| acc_vaddr | input | VA_W | Virtual byte address |
| acc_wdata | input | DATA_W | Write data |
| acc_ready | output | 1 | Access accepted this cycle when `acc_req` is high |
| acc_stall | output | 1 | Accelerator held for a pending miss |
| mem_req | output | 1 | Local-memory access strobe (registered) |
| mem_we | output | 1 | Local-memory write enable |
| mem_paddr | output | PA_W | Local-memory byte address |
| mem_wdata | output | DATA_W | Local-memory write data |
| host_irq | output | 1 | Miss interrupt to host |
| hst_sel | input | 1 | Host register access strobe |
| hst_we | input | 1 | Host register write |
| hst_addr | input | 3 | Host register index |
| hst_wdata | input | 32 | Host write data |
| hst_rdata | output | 32 | Host read data, valid one cycle after a read strobe |

## Verification
The bench installs pages in every slot and sweeps each one with offsets that include the first and last byte of a page. A design that dropped or swapped address bits would put the wrong frame or offset on `mem_paddr`.

Around a miss, the bench moves the accelerator's request to other addresses while the stall is held. A fault latch that kept tracking the request would report the wrong address. The bench also counts memory strobes across the resume: a retry that was lost gives zero strobes, and one that was replayed gives two.

Dropping a dirty slot, resuming without installing a page, and mapping one page twice are all exercised. A design that left stale dirty bits, hung after an unresolved resume, or chose the wrong duplicate slot would each show a mismatch at the ports.

// File: rtl/pagewin_pkg.sv
package pagewin_pkg;

  typedef enum logic [2:0] {
    REG_FAULT_VA = 3'd0,
    REG_STATUS   = 3'd1,
    REG_VALID    = 3'd2,
    REG_DIRTY    = 3'd3,
    REG_SLOT     = 3'd4,
    REG_VPN      = 3'd5,
    REG_DROP     = 3'd6,
    REG_CLEAN    = 3'd7
  } hreg_e;

  typedef enum logic {
    FLT_IDLE = 1'b0,
    FLT_WAIT = 1'b1
  } flt_state_e;

endpackage

// File: rtl/pagewin_table.sv
module pagewin_table #(
  parameter int PAGES = 8,
  parameter int VPN_W = 20,
  localparam int IDX_W = $clog2(PAGES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [VPN_W-1:0] lk_vpn,
  output logic             lk_hit,
  output logic [IDX_W-1:0] lk_idx,
  input  logic             dirty_set,
  input  logic [IDX_W-1:0] dirty_idx,
  input  logic             ins_en,
  input  logic [IDX_W-1:0] ins_idx,
  input  logic [VPN_W-1:0] ins_vpn,
  input  logic             drop_en,
  input  logic [IDX_W-1:0] drop_idx,
  input  logic             clean_en,
  input  logic [IDX_W-1:0] clean_idx,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [VPN_W-1:0] rd_vpn,
  output logic [PAGES-1:0] valid_mask,
  output logic [PAGES-1:0] dirty_mask
);

  logic [VPN_W-1:0] vpn_q [PAGES];
  logic [PAGES-1:0] valid_q;
  logic [PAGES-1:0] dirty_q;
  logic [PAGES-1:0] match;

  // Per-slot state; host operations take priority over the dirty update
  for (genvar s = 0; s < PAGES; s++) begin : g_slot
    assign match[s] = valid_q[s] && (vpn_q[s] == lk_vpn);

    always_ff @(posedge clk) begin
      if (rst) begin
        valid_q[s] <= 1'b0;
        dirty_q[s] <= 1'b0;
        vpn_q[s]   <= '0;
      end else if (ins_en && ins_idx == IDX_W'(s)) begin
        valid_q[s] <= 1'b1;
        dirty_q[s] <= 1'b0;
        vpn_q[s]   <= ins_vpn;
      end else if (drop_en && drop_idx == IDX_W'(s)) begin
        valid_q[s] <= 1'b0;
        dirty_q[s] <= 1'b0;
      end else if (clean_en && clean_idx == IDX_W'(s)) begin
        dirty_q[s] <= 1'b0;
      end else if (dirty_set && dirty_idx == IDX_W'(s)) begin
        dirty_q[s] <= 1'b1;
      end
    end
  end

  // Lowest matching slot wins
  always_comb begin
    lk_idx = '0;
    for (int i = PAGES - 1; i >= 0; i--) begin
      if (match[i]) lk_idx = IDX_W'(i);
    end
  end

  assign lk_hit     = |match;
  assign rd_vpn     = vpn_q[rd_idx];
  assign valid_mask = valid_q;
  assign dirty_mask = dirty_q;

  assert_install_valid_R7: assert property (@(posedge clk) disable iff (rst)
    ins_en |=> valid_mask[$past(ins_idx)] && !dirty_mask[$past(ins_idx)]);

  assert_drop_clears_R8: assert property (@(posedge clk) disable iff (rst)
    drop_en |=> !valid_mask[$past(drop_idx)] && !dirty_mask[$past(drop_idx)]);

endmodule

// File: rtl/pagewin_fault.sv
module pagewin_fault #(
  parameter int VA_W = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            acc_req,
  input  logic            acc_we,
  input  logic [VA_W-1:0] acc_vaddr,
  input  logic            lk_hit,
  input  logic            resume_wr,
  output logic            busy,
  output logic [VA_W-1:0] fault_va,
  output logic            fault_we
);
  import pagewin_pkg::*;

  flt_state_e state_q;
  logic       miss_det;

  assign miss_det = (state_q == FLT_IDLE) && acc_req && !lk_hit;
  assign busy     = (state_q == FLT_WAIT);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= FLT_IDLE;
      fault_va <= '0;
      fault_we <= 1'b0;
    end else begin
      case (state_q)
        FLT_IDLE: if (miss_det) begin
          state_q  <= FLT_WAIT;
          fault_va <= acc_vaddr;
          fault_we <= acc_we;
        end
        FLT_WAIT: if (resume_wr) state_q <= FLT_IDLE;
        default:  state_q <= FLT_IDLE;
      endcase
    end
  end

  assert_miss_stalls_R3: assert property (@(posedge clk) disable iff (rst)
    (acc_req && !lk_hit && !busy) |=> busy);

  assert_fault_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (busy && !resume_wr) |=> busy && $stable(fault_va) && $stable(fault_we));

  assert_resume_release_R5: assert property (@(posedge clk) disable iff (rst)
    (busy && resume_wr) |=> !busy);

endmodule

// File: rtl/pagewin_regs.sv
module pagewin_regs #(
  parameter int PAGES = 8,
  parameter int VPN_W = 20,
  parameter int VA_W  = 32,
  localparam int IDX_W = $clog2(PAGES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hst_sel,
  input  logic             hst_we,
  input  logic [2:0]       hst_addr,
  input  logic [31:0]      hst_wdata,
  output logic [31:0]      hst_rdata,
  input  logic             busy,
  input  logic [VA_W-1:0]  fault_va,
  input  logic             fault_we,
  input  logic [PAGES-1:0] valid_mask,
  input  logic [PAGES-1:0] dirty_mask,
  input  logic [VPN_W-1:0] rd_vpn,
  output logic [IDX_W-1:0] slot_q,
  output logic             ins_en,
  output logic [VPN_W-1:0] ins_vpn,
  output logic             drop_en,
  output logic             clean_en,
  output logic [IDX_W-1:0] arg_idx,
  output logic             resume_wr
);
  import pagewin_pkg::*;

  hreg_e reg_sel;
  logic  wr;

  assign reg_sel   = hreg_e'(hst_addr);
  assign wr        = hst_sel && hst_we;
  assign ins_en    = wr && reg_sel == REG_VPN;
  assign ins_vpn   = hst_wdata[VPN_W-1:0];
  assign drop_en   = wr && reg_sel == REG_DROP;
  assign clean_en  = wr && reg_sel == REG_CLEAN;
  assign arg_idx   = hst_wdata[IDX_W-1:0];
  assign resume_wr = wr && reg_sel == REG_STATUS && hst_wdata[0] && busy;

  always_ff @(posedge clk) begin
    if (rst) slot_q <= '0;
    else if (wr && reg_sel == REG_SLOT) slot_q <= hst_wdata[IDX_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hst_rdata <= '0;
    end else if (hst_sel && !hst_we) begin
      case (reg_sel)
        REG_FAULT_VA: hst_rdata <= 32'(fault_va);
        REG_STATUS:   hst_rdata <= {30'd0, fault_we && busy, busy};
        REG_VALID:    hst_rdata <= 32'(valid_mask);
        REG_DIRTY:    hst_rdata <= 32'(dirty_mask);
        REG_SLOT:     hst_rdata <= 32'(slot_q);
        REG_VPN:      hst_rdata <= 32'(rd_vpn);
        default:      hst_rdata <= '0;
      endcase
    end
  end

endmodule

// File: rtl/pagewin_xlate.sv
module pagewin_xlate #(
  parameter int VA_W       = 32,
  parameter int DATA_W     = 32,
  parameter int PAGES      = 8,
  parameter int PAGE_BYTES = 4096,
  localparam int OFF_W = $clog2(PAGE_BYTES),
  localparam int IDX_W = $clog2(PAGES),
  localparam int VPN_W = VA_W - OFF_W,
  localparam int PA_W  = IDX_W + OFF_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              acc_req,
  input  logic              acc_we,
  input  logic [VA_W-1:0]   acc_vaddr,
  input  logic [DATA_W-1:0] acc_wdata,
  output logic              acc_ready,
  output logic              acc_stall,
  output logic              mem_req,
  output logic              mem_we,
  output logic [PA_W-1:0]   mem_paddr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              host_irq,
  input  logic              hst_sel,
  input  logic              hst_we,
  input  logic [2:0]        hst_addr,
  input  logic [31:0]       hst_wdata,
  output logic [31:0]       hst_rdata
);

  logic             lk_hit;
  logic [IDX_W-1:0] lk_idx;
  logic             busy;
  logic             accept;
  logic [VA_W-1:0]  fault_va;
  logic             fault_we;
  logic [PAGES-1:0] valid_mask;
  logic [PAGES-1:0] dirty_mask;
  logic [VPN_W-1:0] rd_vpn;
  logic [IDX_W-1:0] slot_q;
  logic             ins_en;
  logic [VPN_W-1:0] ins_vpn;
  logic             drop_en;
  logic             clean_en;
  logic [IDX_W-1:0] arg_idx;
  logic             resume_wr;

  assign acc_ready = lk_hit && !busy;
  assign accept    = acc_req && acc_ready;
  assign acc_stall = busy;
  assign host_irq  = busy;

  pagewin_table #(.PAGES(PAGES), .VPN_W(VPN_W)) u_table (
    .clk(clk), .rst(rst),
    .lk_vpn(acc_vaddr[VA_W-1:OFF_W]), .lk_hit(lk_hit), .lk_idx(lk_idx),
    .dirty_set(accept && acc_we), .dirty_idx(lk_idx),
    .ins_en(ins_en), .ins_idx(slot_q), .ins_vpn(ins_vpn),
    .drop_en(drop_en), .drop_idx(arg_idx),
    .clean_en(clean_en), .clean_idx(arg_idx),
    .rd_idx(slot_q), .rd_vpn(rd_vpn),
    .valid_mask(valid_mask), .dirty_mask(dirty_mask)
  );

  pagewin_fault #(.VA_W(VA_W)) u_fault (
    .clk(clk), .rst(rst),
    .acc_req(acc_req), .acc_we(acc_we), .acc_vaddr(acc_vaddr),
    .lk_hit(lk_hit), .resume_wr(resume_wr),
    .busy(busy), .fault_va(fault_va), .fault_we(fault_we)
  );

  pagewin_regs #(.PAGES(PAGES), .VPN_W(VPN_W), .VA_W(VA_W)) u_regs (
    .clk(clk), .rst(rst),
    .hst_sel(hst_sel), .hst_we(hst_we), .hst_addr(hst_addr),
    .hst_wdata(hst_wdata), .hst_rdata(hst_rdata),
    .busy(busy), .fault_va(fault_va), .fault_we(fault_we),
    .valid_mask(valid_mask), .dirty_mask(dirty_mask), .rd_vpn(rd_vpn),
    .slot_q(slot_q), .ins_en(ins_en), .ins_vpn(ins_vpn),
    .drop_en(drop_en), .clean_en(clean_en), .arg_idx(arg_idx),
    .resume_wr(resume_wr)
  );

  // Registered local-memory side
  always_ff @(posedge clk) begin
    if (rst) begin
      mem_req   <= 1'b0;
      mem_we    <= 1'b0;
      mem_paddr <= '0;
      mem_wdata <= '0;
    end else begin
      mem_req <= accept;
      if (accept) begin
        mem_we    <= acc_we;
        mem_paddr <= {lk_idx, acc_vaddr[OFF_W-1:0]};
        mem_wdata <= acc_wdata;
      end
    end
  end

  assert_no_mem_in_stall_R3: assert property (@(posedge clk) disable iff (rst)
    acc_stall |=> !mem_req);

  assert_mem_from_accept_R2: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> $past(acc_req && acc_ready));

  assert_offset_kept_R2: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> mem_paddr[OFF_W-1:0] == $past(acc_vaddr[OFF_W-1:0]));

  assert_stall_cause_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(acc_stall) |-> $past(acc_req && !acc_ready));

endmodule

// File: tb/test_pagewin_xlate.sv
module test_pagewin_xlate;
  localparam int VA_W = 32, DATA_W = 32, PAGES = 4, PAGE_BYTES = 4096;
  localparam int OFF_W = 12, PA_W = 14;

  logic clk = 1'b0, rst = 1'b1;
  logic acc_req = 0, acc_we = 0;
  logic [VA_W-1:0] acc_vaddr = '0;
  logic [DATA_W-1:0] acc_wdata = '0;
  logic acc_ready, acc_stall, mem_req, mem_we, host_irq;
  logic [PA_W-1:0] mem_paddr;
  logic [DATA_W-1:0] mem_wdata;
  logic hst_sel = 0, hst_we = 0;
  logic [2:0] hst_addr = '0;
  logic [31:0] hst_wdata = '0, hst_rdata;

  int nchecks = 0, nerr = 0, mreq_cnt = 0, cyc = 0;
  logic [31:0] rd;

  always #2 clk = ~clk;

  pagewin_xlate #(.VA_W(VA_W), .DATA_W(DATA_W), .PAGES(PAGES), .PAGE_BYTES(PAGE_BYTES))
    i_pagewin_xlate (.*);

  always @(negedge clk) if (mem_req) mreq_cnt++;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nchecks++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("  Simulation finished: %0d checks, %0d errors", nchecks, nerr);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      nchecks++; nerr++;
      $display("FAIL watchdog: actual %0d expected < 100000", cyc);
      summary();
    end
  end

  task automatic host_wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); hst_sel = 1; hst_we = 1; hst_addr = a; hst_wdata = d;
    @(negedge clk); hst_sel = 0; hst_we = 0;
  endtask

  task automatic host_rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); hst_sel = 1; hst_we = 0; hst_addr = a;
    @(negedge clk); hst_sel = 0; d = hst_rdata;
  endtask

  function automatic logic [19:0] vpn_of(input int s);
    return 20'h100 + 20'(s) * 20'h33;
  endfunction

  task automatic acc_hit(input string req, input logic we, input logic [31:0] va,
                         input logic [31:0] wd, input logic [PA_W-1:0] exp_pa);
    @(negedge clk); acc_req = 1; acc_we = we; acc_vaddr = va; acc_wdata = wd;
    #1 chk(acc_ready === 1'b1, req, "ready on hit", 32'(acc_ready), 1);
    @(negedge clk);
    acc_req = 0;
    chk(mem_req === 1'b1 && mem_paddr === exp_pa, req, "paddr",
        32'(mem_paddr), 32'(exp_pa));
    chk(mem_we === we, req, "mem_we", 32'(mem_we), 32'(we));
    if (we) chk(mem_wdata === wd, req, "mem_wdata", mem_wdata, wd);
  endtask

  task automatic acc_miss(input logic we, input logic [31:0] va);
    @(negedge clk); acc_req = 1; acc_we = we; acc_vaddr = va; acc_wdata = 32'hDEAD0000;
    #1 chk(acc_ready === 1'b0, "R3", "ready on miss", 32'(acc_ready), 0);
    @(negedge clk);
    chk(acc_stall === 1'b1 && host_irq === 1'b1, "R3", "stall+irq",
        {30'd0, acc_stall, host_irq}, 3);
  endtask

  initial begin
    int base;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk(mem_req === 0 && acc_stall === 0 && host_irq === 0, "R1", "outputs",
        {29'd0, mem_req, acc_stall, host_irq}, 0);
    host_rd(3'd2, rd); chk(rd === 0, "R1", "valid mask", rd, 0);
    host_rd(3'd3, rd); chk(rd === 0, "R1", "dirty mask", rd, 0);

    // R7 install every slot and read back
    for (int s = 0; s < PAGES; s++) begin
      host_wr(3'd4, 32'(s));
      host_wr(3'd5, 32'(vpn_of(s)));
      host_rd(3'd5, rd); chk(rd === 32'(vpn_of(s)), "R7", "vpn readback", rd, 32'(vpn_of(s)));
    end
    host_rd(3'd2, rd); chk(rd === 32'hF, "R7", "valid mask", rd, 32'hF);

    // R2 sweep of slots and offsets, reads only
    for (int s = 0; s < PAGES; s++) begin
      for (int k = 0; k < 4; k++) begin
        logic [11:0] off;
        off = (k == 0) ? 12'h000 : (k == 1) ? 12'hFFF : (k == 2) ? 12'h5A4 : 12'(s * 12'h111);
        acc_hit("R2", 1'b0, {vpn_of(s), off}, 32'h0, {2'(s), off});
      end
    end
    host_rd(3'd3, rd); chk(rd === 0, "R6", "reads leave dirty clear", rd, 0);

    // R6 write hit sets dirty, clean clears it
    acc_hit("R6", 1'b1, {vpn_of(2), 12'h040}, 32'hA5A5_0002, {2'd2, 12'h040});
    host_rd(3'd3, rd); chk(rd === 32'h4, "R6", "dirty after write", rd, 32'h4);
    host_wr(3'd7, 32'd2);
    host_rd(3'd3, rd); chk(rd === 0, "R6", "dirty after clean", rd, 0);

    // R3/R4/R5 miss, hold, resume
    host_rd(3'd1, rd); chk(rd === 0, "R4", "status idle", rd, 0);
    base = mreq_cnt;
    acc_miss(1'b1, 32'h0077_7ABC);
    acc_vaddr = {vpn_of(0), 12'h010}; acc_we = 0;
    repeat (4) @(negedge clk);
    chk(acc_stall === 1 && acc_ready === 0, "R3", "held while stalled",
        {30'd0, acc_stall, acc_ready}, 2);
    host_rd(3'd0, rd); chk(rd === 32'h0077_7ABC, "R4", "fault va", rd, 32'h0077_7ABC);
    host_rd(3'd1, rd); chk(rd === 32'h3, "R4", "status write pending", rd, 32'h3);
    acc_vaddr = 32'h0077_7ABC; acc_we = 1;
    host_wr(3'd4, 32'd1);
    host_wr(3'd5, 32'h777);
    chk(mreq_cnt == base, "R3", "no mem_req during stall", 32'(mreq_cnt - base), 0);
    host_wr(3'd1, 32'd1);
    chk(acc_stall === 0 && host_irq === 0, "R5", "released", {30'd0, acc_stall, host_irq}, 0);
    #1 chk(acc_ready === 1, "R5", "retry ready", 32'(acc_ready), 1);
    @(negedge clk); acc_req = 0;
    chk(mem_paddr === {2'd1, 12'hABC} && mem_we === 1, "R5", "retry paddr",
        32'(mem_paddr), 32'({2'd1, 12'hABC}));
    repeat (3) @(negedge clk);
    chk(mreq_cnt - base == 1, "R5", "exactly one strobe", 32'(mreq_cnt - base), 1);
    host_rd(3'd3, rd); chk(rd === 32'h2, "R6", "retried write dirty", rd, 32'h2);

    // R8 drop a dirty slot; access misses; resume without install misses again
    acc_hit("R8", 1'b1, {vpn_of(3), 12'h008}, 32'h1234, {2'd3, 12'h008});
    host_wr(3'd6, 32'd3);
    host_rd(3'd2, rd); chk(rd === 32'h7, "R8", "valid after drop", rd, 32'h7);
    host_rd(3'd3, rd); chk(rd === 32'h2, "R8", "dirty after drop", rd, 32'h2);
    acc_miss(1'b0, {vpn_of(3), 12'h008});
    host_rd(3'd1, rd); chk(rd === 32'h1, "R4", "status read pending", rd, 32'h1);
    host_wr(3'd1, 32'd1);
    @(negedge clk);
    chk(acc_stall === 1, "R5", "unresolved retry misses again", 32'(acc_stall), 1);
    host_wr(3'd4, 32'd3);
    host_wr(3'd5, 32'(vpn_of(3)));
    host_wr(3'd1, 32'd1);
    #1 chk(acc_ready === 1, "R5", "ready after install", 32'(acc_ready), 1);
    @(negedge clk); acc_req = 0;
    chk(mem_paddr === {2'd3, 12'h008}, "R5", "paddr after install",
        32'(mem_paddr), 32'({2'd3, 12'h008}));

    // R9 duplicate mapping picks lower slot
    host_wr(3'd4, 32'd3);
    host_wr(3'd5, 32'(vpn_of(2)));
    acc_hit("R9", 1'b0, {vpn_of(2), 12'h321}, 32'h0, {2'd2, 12'h321});

    summary();
  end
endmodule